// File: doc/BRIEF.md
# Framebuffer Constant-Fill Writer

This block produces the stream of memory writes that paints a rectangle of the framebuffer with one constant value. It serves both background color clears and depth-buffer clears. Software loads a 32-bit fill register that holds two 16-bit pixels, usually the same value in both halves. The block widens each pixel to the 18-bit stored width and packs the pair into one 36-bit memory word.

A start pulse supplies a base pointer, the rectangle's width and height counted in pixel pairs (memory words), and a row stride, also counted in words. The block then walks the rectangle row by row from the top-left word. It presents one word at a time on a valid/ready write port and signals completion with a single-cycle done pulse. If the base pointer is not on a 64-bit boundary, the block reports an error and writes nothing. An empty rectangle ends at once, without an error.

Top module: `fbfill_writer`

## Requirements
- R1: After reset, busy, done, err_align and mem_valid are all low.
- R2: Each 16-bit half p of the fill value is widened to the 18-bit value {p, p[1:0]}. mem_data[35:18] carries the widened upper half (fill bits 31:16), which belongs to the lower address. mem_data[17:0] carries the widened lower half.
- R3: Word (x, y) of the rectangle is written at address base + (y*stride + x)*4, truncated to the address width. Words are issued in order with x varying fastest, starting at (0, 0).
- R4: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold their values. The walk advances only on a cycle in which both are high.
- R5: Exactly width*height words are written. done is high for exactly one cycle: the cycle after the last word is accepted. busy is low in the cycle after that.
- R6: A start whose base has any of bits 2:0 set raises done and err_align together in the next cycle, and no write is issued.
- R7: A start with width or height equal to zero raises done in the next cycle, with err_align low and no write issued.
- R8: A fill-register write during a fill does not change mem_data for that fill. The new value is used from the next start onward.
- R9: A start pulse while busy is high is ignored. The fill in progress keeps its addresses and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Fill-register write strobe |
| reg_wdata | input | 32 | Fill-register write value (two 16-bit pixels) |
| start | input | 1 | Begin a fill; sampled only when idle |
| base | input | 24 | Byte address of the top-left word |
| width | input | 12 | Rectangle width in words |
| height | input | 12 | Rectangle height in rows |
| stride | input | 12 | Row pitch in words |
| busy | output | 1 | High from the accepted start until done has been shown |
| done | output | 1 | One-cycle completion pulse |
| err_align | output | 1 | High with done when the base pointer was misaligned |
| mem_valid | output | 1 | A write word is offered |
| mem_addr | output | 24 | Byte address of the offered word |
| mem_data | output | 36 | Two packed 18-bit pixels |
| mem_ready | input | 1 | Memory accepts the offered word |

## Verification
On every cycle, the assertions check that the offer stays stable under backpressure, that the fill word stays constant across a fill, that done lasts one cycle, that a misaligned start ends with an error, that a start during a fill cannot end it, and that the column counter stays inside the width. Only the bench scenarios can show that each word appears at its row-major address with the correct widened pixels, that the total word count is right, and that a register write made mid-fill takes effect on the following fill.

// File: rtl/fbfill_pkg.sv
package fbfill_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } fill_state_e;
endpackage

// File: rtl/fbfill_widen.sv
// Expands packed narrow pixels into the wider stored format by appending
// copies of each pixel's low-order bits.
module fbfill_widen #(
   parameter int PIX_W       = 16,
   parameter int EXT_W       = 2,
   parameter int NPIX        = 2,
   parameter bit UPPER_FIRST = 1'b1
) (
   input  logic [NPIX*PIX_W-1:0]         fill_i,
   output logic [NPIX*(PIX_W+EXT_W)-1:0] word_o
);
   localparam int OUT_W = PIX_W + EXT_W;

   if (EXT_W > PIX_W || EXT_W < 1) begin : g_bad_ext
      $error("fbfill_widen: EXT_W must be in 1..PIX_W");
   end
   if (NPIX < 1) begin : g_bad_npix
      $error("fbfill_widen: NPIX must be at least 1");
   end

   for (genvar g = 0; g < NPIX; g++) begin : g_pix
      localparam int SRC = UPPER_FIRST ? g : (NPIX - 1 - g);
      logic [PIX_W-1:0] pix;
      assign pix = fill_i[SRC*PIX_W +: PIX_W];
      assign word_o[g*OUT_W +: OUT_W] = {pix, pix[EXT_W-1:0]};
   end
endmodule

// File: rtl/fbfill_walker.sv
// Row-major rectangle walker: keeps column/row counters and the byte address
// of the current word.
module fbfill_walker #(
   parameter int ADDR_W     = 24,
   parameter int DIM_W      = 12,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DIM_W-1:0]  width_i,
   input  logic [DIM_W-1:0]  height_i,
   input  logic [DIM_W-1:0]  stride_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam int SH = $clog2(WORD_BYTES);

   if ((1 << SH) != WORD_BYTES) begin : g_bad_wb
      $error("fbfill_walker: WORD_BYTES must be a power of two");
   end
   if (ADDR_W <= DIM_W + SH) begin : g_bad_aw
      $error("fbfill_walker: ADDR_W too narrow for stride range");
   end

   logic [DIM_W-1:0]  x_q, y_q, w_q, h_q, str_q;
   logic [ADDR_W-1:0] row_q, addr_q, pitch;
   logic              act_q, row_end;

   assign pitch   = ADDR_W'(str_q) << SH;
   assign row_end = (x_q == w_q - 1'b1);
   assign last_o  = row_end && (y_q == h_q - 1'b1);
   assign addr_o  = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         w_q    <= '0;
         h_q    <= '0;
         str_q  <= '0;
         row_q  <= '0;
         addr_q <= '0;
         act_q  <= 1'b0;
      end else if (load_i) begin
         x_q    <= '0;
         y_q    <= '0;
         w_q    <= width_i;
         h_q    <= height_i;
         str_q  <= stride_i;
         row_q  <= base_i;
         addr_q <= base_i;
         act_q  <= 1'b1;
      end else if (step_i && act_q) begin
         if (row_end) begin
            x_q    <= '0;
            y_q    <= y_q + 1'b1;
            row_q  <= row_q + pitch;
            addr_q <= row_q + pitch;
            if (last_o) act_q <= 1'b0;
         end else begin
            x_q    <= x_q + 1'b1;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
         end
      end
   end

   // R3
   col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (x_q < w_q) && (y_q < h_q));

   // R5
   step_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> act_q);
endmodule

// File: rtl/fbfill_writer.sv
module fbfill_writer #(
   parameter int ADDR_W      = 24,
   parameter int DIM_W       = 12,
   parameter int PIX_W       = 16,
   parameter int EXT_W       = 2,
   parameter int NPIX        = 2,
   parameter int ALIGN_BYTES = 8,
   parameter bit UPPER_FIRST = 1'b1,
   localparam int FILL_W     = NPIX * PIX_W,
   localparam int DATA_W     = NPIX * (PIX_W + EXT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [FILL_W-1:0] reg_wdata,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [DIM_W-1:0]  width,
   input  logic [DIM_W-1:0]  height,
   input  logic [DIM_W-1:0]  stride,
   output logic              busy,
   output logic              done,
   output logic              err_align,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ready
);
   import fbfill_pkg::*;

   localparam int WORD_BYTES = NPIX * PIX_W / 8;
   localparam int AL_BITS    = $clog2(ALIGN_BYTES);

   if ((1 << AL_BITS) != ALIGN_BYTES || AL_BITS < 1) begin : g_bad_align
      $error("fbfill_writer: ALIGN_BYTES must be a power of two >= 2");
   end
   if ((NPIX * PIX_W) % 8 != 0) begin : g_bad_word
      $error("fbfill_writer: fill word must be whole bytes");
   end

   fill_state_e       state_q;
   logic [FILL_W-1:0] fill_reg_q, fill_act_q;
   logic              err_q;
   logic              start_ok, misaligned, empty, walk_load, walk_last, step;

   assign start_ok   = start && (state_q == ST_IDLE);
   assign misaligned = |base[AL_BITS-1:0];
   assign empty      = (width == '0) || (height == '0);
   assign walk_load  = start_ok && !misaligned && !empty;
   assign step       = mem_valid && mem_ready;

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign err_align = done && err_q;
   assign mem_valid = (state_q == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_reg_q <= '0;
      else if (reg_we) fill_reg_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fill_act_q <= '0;
         err_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_ok) begin
               err_q      <= misaligned;
               fill_act_q <= fill_reg_q;
               state_q    <= (misaligned || empty) ? ST_DONE : ST_RUN;
            end
            ST_RUN:  if (step && walk_last) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   fbfill_walker #(
      .ADDR_W     (ADDR_W),
      .DIM_W      (DIM_W),
      .WORD_BYTES (WORD_BYTES)
   ) walk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (walk_load),
      .base_i   (base),
      .width_i  (width),
      .height_i (height),
      .stride_i (stride),
      .step_i   (step),
      .addr_o   (mem_addr),
      .last_o   (walk_last)
   );

   fbfill_widen #(
      .PIX_W       (PIX_W),
      .EXT_W       (EXT_W),
      .NPIX        (NPIX),
      .UPPER_FIRST (UPPER_FIRST)
   ) widen_i (
      .fill_i (fill_act_q),
      .word_o (mem_data)
   );

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R6
   misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && misaligned |=> done && err_align && !mem_valid);

   // R8
   fill_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && $past(mem_valid) |-> $stable(mem_data));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready && start |=> mem_valid);
endmodule

// File: tb/fbfill_writer_tb.sv
module fbfill_writer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        start = 1'b0;
   logic [23:0] base = '0;
   logic [11:0] width = '0, height = '0, stride = '0;
   logic        busy, done, err_align, mem_valid, mem_ready = 1'b0;
   logic [23:0] mem_addr;
   logic [35:0] mem_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [31:0] model_fill = '0;

   always #2 clk = ~clk;

   fbfill_writer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .start(start), .base(base), .width(width), .height(height),
      .stride(stride), .busy(busy), .done(done), .err_align(err_align),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
      .mem_ready(mem_ready)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000 && !finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] exp_word(input logic [31:0] f);
      return {f[31:16], f[17:16], f[15:0], f[1:0]};
   endfunction

   function automatic logic [23:0] exp_addr(input logic [23:0] b, input int s,
                                            input int x, input int y);
      return b + 24'((y * s + x) * 4);
   endfunction

   task automatic write_fill(input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      model_fill = v;
   endtask

   // poke: write the fill register and pulse start during the fill (R8, R9)
   task automatic run_fill(input logic [23:0] b, input int w, input int h,
                           input int s, input bit poke);
      logic [31:0] snap;
      bit expect_err;
      int n, idx;
      bit acc;
      snap = model_fill;
      expect_err = (b[2:0] != 3'd0);
      n = w * h;
      @(negedge clk);
      start = 1'b1; base = b; width = 12'(w); height = 12'(h); stride = 12'(s);
      @(negedge clk);
      start = 1'b0;
      if (expect_err || n == 0) begin
         chk(done == 1'b1, expect_err ? "R6 done" : "R7 done", 64'(done), 64'd1);
         chk(err_align == expect_err, expect_err ? "R6 err" : "R7 err",
             64'(err_align), 64'(expect_err));
         chk(mem_valid == 1'b0, expect_err ? "R6 no write" : "R7 no write",
             64'(mem_valid), 64'd0);
         @(negedge clk);
         chk(!done && !busy && !mem_valid, "R5 idle after done",
             {61'd0, done, busy, mem_valid}, 64'd0);
         return;
      end
      idx = 0;
      while (idx < n && cyc < 90000) begin
         chk(mem_valid == 1'b1, "R4 valid held", 64'(mem_valid), 64'd1);
         chk(mem_addr == exp_addr(b, s, idx % w, idx / w), "R3 address",
             64'(mem_addr), 64'(exp_addr(b, s, idx % w, idx / w)));
         chk(mem_data == exp_word(snap), "R2 data", 64'(mem_data),
             64'(exp_word(snap)));
         if (poke && idx == 1) begin
            reg_we = 1'b1;
            reg_wdata = $urandom;
            model_fill = reg_wdata;
            start = 1'b1;
            base = b + 24'h100;
            width = 12'd1;
            height = 12'd1;
         end
         acc = ($urandom % 3) != 0;
         mem_ready = acc;
         @(negedge clk);
         reg_we = 1'b0;
         start = 1'b0;
         mem_ready = 1'b0;
         if (acc) idx++;
      end
      chk(done == 1'b1 && err_align == 1'b0, "R5 done after last",
          {62'd0, done, err_align}, 64'd2);
      chk(mem_valid == 1'b0, "R5 word count", 64'(mem_valid), 64'd0);
      @(negedge clk);
      chk(!done && !busy, "R5 single pulse", {62'd0, done, busy}, 64'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #1;
      chk(!busy && !done && !err_align && !mem_valid, "R1 reset",
          {60'd0, busy, done, err_align, mem_valid}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err_align && !mem_valid, "R1 after release",
          {60'd0, busy, done, err_align, mem_valid}, 64'd0);

      // R2 distinct halves, low bits differ
      write_fill(32'h8001_7FFE);
      run_fill(24'h000100, 1, 1, 1, 1'b0);
      // R3 row wrap with stride wider than width
      write_fill(32'hF00D_F00D);
      run_fill(24'h001000, 3, 2, 5, 1'b0);
      // R6 misaligned base
      run_fill(24'h000204, 2, 2, 2, 1'b0);
      run_fill(24'h000201, 1, 1, 1, 1'b0);
      // R7 empty rectangles
      run_fill(24'h000300, 0, 3, 4, 1'b0);
      run_fill(24'h000300, 4, 0, 4, 1'b0);
      // R8 R9 mid-fill register write and stray start
      write_fill(32'h1234_5678);
      run_fill(24'h002000, 4, 3, 6, 1'b1);
      // R8 new value now active
      run_fill(24'h003000, 2, 1, 2, 1'b0);
      // R3 address wrap at top of space
      run_fill(24'hFFFFF8, 2, 2, 3, 1'b0);

      for (int k = 0; k < 25; k++) begin
         int w, h, s;
         logic [23:0] b;
         if (($urandom % 3) == 0) write_fill($urandom);
         w = 1 + ($urandom % 6);
         h = 1 + ($urandom % 4);
         s = w + ($urandom % 6);
         b = 24'($urandom) & 24'hFFFFF8;
         if (($urandom % 8) == 0) b[1:0] = 2'b10;
         run_fill(b, w, h, s, ($urandom % 4) == 0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule